// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block gives a host two word-wide ports for reaching the configuration registers of a small, fixed set of on-chip functions. The host first writes a 32-bit selector (slot number plus dword index) into the address port. It then reads or writes the selected dword through the data window. Each function's register space lives in register storage inside the block. Word 0 of each space comes out of reset holding that function's identity value. The other words clear to zero.

Both ports use one plain strobe bus with per-byte lane enables. The bus has no back-pressure. A write strobe is taken in the cycle it is raised, and read data is combinational from registered state. A selector lookup is only performed when the highest selector byte is written. The result is latched into a response register and a status register, and later reads of the two ports return those. A particular change to the function-number bits of the selector is treated as a reset request. It produces a single-cycle pulse on an output pin, and that selector byte is not stored.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the status and response registers read zero, the selector is zero and `rst_pulse` is low.
- R2: Writing selector lane 0 stores its byte with bits 1:0 forced to zero, so byte values 0x04, 0x05 and 0x07 all select dword index 1.
- R3: A selector write whose lane 3 is not enabled performs no lookup and leaves the status and response registers unchanged. A write that enables lane 3 performs the lookup on the selector as updated by that same write, with the result visible from the next cycle.
- R4: Selector layout: bit 31 enable, bits 23:16 bus, bits 15:11 device, bits 10:8 function, bits 7:2 dword index. Slot {bus,device,function} matching a configured function gives status 0x80000000 and response equal to the addressed dword.
- R5: For a present slot whose dword index is at or beyond the implemented depth, the response is 0x00000000 and the status is 0x80000000.
- R6: For a slot with no function, the response is 0xFFFFFFFF and the status is 0x00000000.
- R7: A data-window write enables lane n to write byte n of the selected dword. This covers single bytes, halfwords at lanes 0 and 2, and whole dwords. Lanes that are not enabled keep their old value.
- R8: Data-window writes to an absent slot, or to an index beyond the implemented depth, change no stored byte in any function.
- R9: If selector byte 1 currently has bits 2:1 equal to 01 and a lane-1 write carries bits 2:1 equal to 11, `rst_pulse` is high for exactly the next cycle and byte 1 keeps its old value. Any other lane-1 write is stored, with no pulse.
- R10: While `io_rd` is high, `io_rdata` returns the response register when `io_sel`=1 and the status register when `io_sel`=0. It returns zero while `io_rd` is low. A data-window write does not refresh the response until the next lookup.
- R11: Selector bit 31 has no effect on the lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe, taken in the cycle it is high |
| io_rd | input | 1 | Read strobe |
| io_sel | input | 1 | 0 = address/status port, 1 = data window |
| io_be | input | 4 | Byte-lane enables for writes |
| io_wdata | input | 32 | Write data, lane n on bits 8n+7:8n |
| io_rdata | output | 32 | Read data (status or response) |
| rst_pulse | output | 1 | One-cycle reset request |

## Verification
The bench steps the selector one lane at a time to show that the registers move only on the lane-3 write. A design that looked up on every selector write would show a new response too early. Out-of-depth indices are written and read back, and the neighbouring in-range dword is checked too. This catches an index that wraps around instead of being dropped, and a miss that wrongly returns all ones for a present function. The reset request is exercised in three forms: trigger, repeat lookup and non-trigger. The repeat lookup on the surviving function number exposes a design that stores the triggering byte. The non-trigger form exposes a design that pulses without checking the current byte.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int SLOT_W = 16;
  localparam int IDX_W  = 6;
  localparam logic [31:0] STATUS_HIT = 32'h8000_0000;
  localparam logic [31:0] RESP_MISS  = 32'hFFFF_FFFF;
  // selector bit positions
  localparam int SLOT_LSB = 8;
  localparam int IDX_LSB  = 2;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic [IDX_W-1:0]  nxt_idx,
  output logic              lookup_go,
  output logic              pulse_q
);
  logic [31:0] sel_q, sel_nxt;
  logic        trig;

  always_comb begin
    trig    = wr_en && be[1] && (sel_q[10:9] == 2'b01) && (wdata[10:9] == 2'b11);
    sel_nxt = sel_q;
    if (wr_en) begin
      if (be[0])         sel_nxt[7:0]   = {wdata[7:2], 2'b00};
      if (be[1] && !trig) sel_nxt[15:8] = wdata[15:8];
      if (be[2])         sel_nxt[23:16] = wdata[23:16];
      if (be[3])         sel_nxt[31:24] = wdata[31:24];
    end
  end

  assign lookup_go = wr_en && be[3];
  assign cur_slot  = sel_q[SLOT_LSB +: SLOT_W];
  assign cur_idx   = sel_q[IDX_LSB +: IDX_W];
  assign nxt_slot  = sel_nxt[SLOT_LSB +: SLOT_W];
  assign nxt_idx   = sel_nxt[IDX_LSB +: IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      sel_q   <= sel_nxt;
      pulse_q <= trig;
    end
  end

  AST_PULSE_KEEPS_BYTE1: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (sel_q[15:8] == $past(sel_q[15:8]))); // R9
  AST_PULSE_NEEDS_LANE1: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(wr_en && be[1])); // R9
endmodule

// File: rtl/cfg_space.sv
module cfg_space
  import cfgport_pkg::*;
#(
  parameter int          DWORDS = 16,
  parameter logic [31:0] INIT0  = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data
);
  localparam int AW = $clog2(DWORDS);

  logic [DWORDS-1:0][31:0] mem_q;
  logic wr_ok, rd_ok;

  assign wr_ok   = wr_en && (32'(wr_idx) < DWORDS);
  assign rd_ok   = 32'(rd_idx) < DWORDS;
  assign rd_data = rd_ok ? mem_q[rd_idx[AW-1:0]] : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q    <= '0;
      mem_q[0] <= INIT0;
    end else if (wr_ok) begin
      for (int b = 0; b < 4; b++)
        if (wr_be[b]) mem_q[wr_idx[AW-1:0]][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  AST_IDLE_SPACE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q)); // R8
  AST_DEEP_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(wr_idx) >= DWORDS) |=> $stable(mem_q)); // R8
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfgport_pkg::*;
#(
  parameter int                     NUM_DEV    = 2,
  parameter int                     DEV_DWORDS = 16,
  parameter logic [NUM_DEV*16-1:0]  SLOT_IDS   = {16'h0002, 16'h0000},
  parameter logic [NUM_DEV*32-1:0]  DEV_IDS    = {32'h5678_0042, 32'h1234_ABCD}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic        io_sel,
  input  logic [3:0]  io_be,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        rst_pulse
);
  logic [SLOT_W-1:0] cur_slot, nxt_slot;
  logic [IDX_W-1:0]  cur_idx, nxt_idx;
  logic              lookup_go;
  logic [NUM_DEV-1:0] look_hit, wr_hit;
  logic [31:0]        rd_dw [NUM_DEV];
  logic [31:0]        merged;
  logic [31:0]        resp_q, status_q;

  cfg_addr_reg u_addr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(io_wr && !io_sel), .be(io_be), .wdata(io_wdata),
    .cur_slot(cur_slot), .cur_idx(cur_idx),
    .nxt_slot(nxt_slot), .nxt_idx(nxt_idx),
    .lookup_go(lookup_go), .pulse_q(rst_pulse)
  );

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    assign look_hit[i] = (nxt_slot == SLOT_IDS[i*16 +: 16]);
    assign wr_hit[i]   = (cur_slot == SLOT_IDS[i*16 +: 16]);
    cfg_space #(.DWORDS(DEV_DWORDS), .INIT0(DEV_IDS[i*32 +: 32])) u_space (
      .clk(clk), .rst_n(rst_n),
      .wr_en(io_wr && io_sel && wr_hit[i]),
      .wr_idx(cur_idx), .wr_be(io_be), .wr_data(io_wdata),
      .rd_idx(nxt_idx), .rd_data(rd_dw[i])
    );
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (look_hit[i]) merged = merged | rd_dw[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_q   <= '0;
      status_q <= '0;
    end else if (lookup_go) begin
      if (|look_hit) begin
        status_q <= STATUS_HIT;
        resp_q   <= merged;
      end else begin
        status_q <= '0;
        resp_q   <= RESP_MISS;
      end
    end
  end

  assign io_rdata = !io_rd ? 32'h0 : (io_sel ? resp_q : status_q);

  AST_HOLD_WITHOUT_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_go |=> ($stable(resp_q) && $stable(status_q))); // R3
  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q == 32'h0) && (resp_q != 32'h0)) |-> (resp_q == RESP_MISS)); // R6
endmodule

// File: tb/test_cfg_port_decoder.sv
module test_cfg_port_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0, io_sel = 1'b0;
  logic [3:0]  io_be = 4'h0;
  logic [31:0] io_wdata = 32'h0;
  logic [31:0] io_rdata;
  logic        rst_pulse;
  int n_run = 0, n_fail = 0;

  localparam logic [31:0] HIT = 32'h8000_0000;
  localparam logic [31:0] ID0 = 32'h1234_ABCD;
  localparam logic [31:0] ID1 = 32'h5678_0042;

  always #10 clk = ~clk; // 50 MHz

  cfg_port_decoder #(.NUM_DEV(2), .DEV_DWORDS(16),
    .SLOT_IDS({16'h0002, 16'h0000}), .DEV_IDS({ID1, ID0})) i_cfg_port_decoder (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
    .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata), .rst_pulse(rst_pulse));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_sel = sel; io_be = be; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_be = 4'h0; io_wdata = 32'h0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    io_rd = 1'b1; io_sel = sel;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  function automatic logic [31:0] sa(input logic en, input logic [7:0] bus,
      input logic [4:0] dev, input logic [2:0] fn, input logic [5:0] idx);
    return {en, 7'b0, bus, dev, fn, idx, 2'b00};
  endfunction

  task automatic look(input string req, input logic [31:0] a,
                      input logic [31:0] es, input logic [31:0] er);
    logic [31:0] v;
    wr(1'b0, 4'hF, a);
    rd(1'b0, v); chk({req, " status"}, v, es);
    rd(1'b1, v); chk({req, " response"}, v, er);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(1'b0, v); chk("R1 status", v, 32'h0);
    rd(1'b1, v); chk("R1 response", v, 32'h0);
    chk("R1 pulse", {31'b0, rst_pulse}, 32'h0);
  endtask

  task automatic t_present;
    look("R4 slot0 id", sa(0, 0, 0, 0, 0), HIT, ID0);
    look("R4 slot2 id", sa(0, 0, 0, 2, 0), HIT, ID1);
    look("R6 other bus", sa(0, 8'h01, 0, 0, 0), 32'h0, 32'hFFFF_FFFF);
    look("R6 other dev", sa(0, 0, 5'd5, 0, 0), 32'h0, 32'hFFFF_FFFF);
    look("R11 enable set", sa(1, 0, 0, 0, 0), HIT, ID0);
    look("R11 enable set slot2", sa(1, 0, 0, 2, 0), HIT, ID1);
  endtask

  task automatic t_depth;
    look("R5 idx16", sa(0, 0, 0, 0, 6'd16), HIT, 32'h0);
    look("R5 idx63", sa(0, 0, 0, 2, 6'd63), HIT, 32'h0);
  endtask

  task automatic t_lane3_only;
    logic [31:0] v;
    look("R3 setup", sa(0, 0, 0, 0, 0), HIT, ID0);
    wr(1'b0, 4'b0001, 32'h0000_0004);
    rd(1'b1, v); chk("R3 lane0 no lookup", v, ID0);
    wr(1'b0, 4'b0110, 32'h00FF_FF00);
    rd(1'b0, v); chk("R3 lanes1-2 no lookup status", v, HIT);
    rd(1'b1, v); chk("R3 lanes1-2 no lookup resp", v, ID0);
    wr(1'b0, 4'b1000, 32'h0);
    rd(1'b0, v); chk("R3 lane3 lookup status", v, 32'h0);
    rd(1'b1, v); chk("R3 lane3 lookup resp", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_data;
    logic [31:0] v;
    look("R7 setup", sa(0, 0, 0, 0, 1), HIT, 32'h0);
    wr(1'b1, 4'hF, 32'hDEAD_BEEF);
    rd(1'b1, v); chk("R10 stale response", v, 32'h0);
    look("R7 dword", sa(0, 0, 0, 0, 1), HIT, 32'hDEAD_BEEF);
    wr(1'b1, 4'b1100, 32'h1111_0000);
    look("R7 upper half", sa(0, 0, 0, 0, 1), HIT, 32'h1111_BEEF);
    wr(1'b1, 4'b0011, 32'hFFFF_2222);
    look("R7 lower half", sa(0, 0, 0, 0, 1), HIT, 32'h1111_2222);
    wr(1'b1, 4'b0100, 32'hAA33_BBCC);
    look("R7 byte lane2", sa(0, 0, 0, 0, 1), HIT, 32'h1133_2222);
    look("R7 slot2 untouched", sa(0, 0, 0, 2, 1), HIT, 32'h0);
  endtask

  task automatic t_lowbits;
    look("R2 byte0 07", 32'h0000_0007, HIT, 32'h1133_2222);
    look("R2 byte0 05", 32'h0000_0005, HIT, 32'h1133_2222);
  endtask

  task automatic t_drop;
    look("R8 absent setup", sa(0, 0, 5'd3, 0, 1), 32'h0, 32'hFFFF_FFFF);
    wr(1'b1, 4'hF, 32'hCAFE_0000);
    look("R8 absent slot0", sa(0, 0, 0, 0, 1), HIT, 32'h1133_2222);
    look("R8 absent slot2", sa(0, 0, 0, 2, 1), HIT, 32'h0);
    look("R8 deep setup", sa(0, 0, 0, 0, 6'd17), HIT, 32'h0);
    wr(1'b1, 4'hF, 32'h0000_ABCD);
    look("R8 deep readback", sa(0, 0, 0, 0, 6'd17), HIT, 32'h0);
    look("R8 deep no wrap", sa(0, 0, 0, 0, 1), HIT, 32'h1133_2222);
  endtask

  task automatic t_pulse;
    logic [31:0] v;
    wr(1'b0, 4'hF, sa(0, 0, 0, 2, 0));
    chk("R9 no pulse from 00", {31'b0, rst_pulse}, 32'h0);
    wr(1'b0, 4'b0010, 32'h0000_0600);
    chk("R9 pulse high", {31'b0, rst_pulse}, 32'h1);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'b0, rst_pulse}, 32'h0);
    wr(1'b0, 4'b1000, 32'h0);
    rd(1'b0, v); chk("R9 byte1 kept status", v, HIT);
    rd(1'b1, v); chk("R9 byte1 kept resp", v, ID1);
    wr(1'b0, 4'hF, sa(0, 0, 0, 0, 0));
    wr(1'b0, 4'b0010, 32'h0000_0600);
    chk("R9 non-trigger no pulse", {31'b0, rst_pulse}, 32'h0);
    wr(1'b0, 4'b1000, 32'h0);
    rd(1'b0, v); chk("R9 non-trigger stored", v, 32'h0);
  endtask

  task automatic t_rdgate;
    #1 chk("R10 idle rdata", io_rdata, 32'h0);
    look("R10 status vs response", sa(0, 0, 0, 2, 0), HIT, ID1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_present();
    t_depth();
    t_lane3_only();
    t_data();
    t_lowbits();
    t_drop();
    t_pulse();
    t_rdgate();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule